// File: doc/BRIEF.md
# Background Tile Pixel Fetch Pipeline

This block turns a stream of screen coordinates into background color indices, one per accepted pixel, through a fixed five-stage pipeline. Each coordinate is offset by a global scroll pair and wrapped onto a 640x480 background canvas. The whole canvas scrolls as one plane. The canvas is split into 16x16-pixel tiles, so the canvas is 40 tiles wide and 30 tiles high. For each tile position an attribute entry is fetched. It gives a tile index (1024 tiles), a horizontal flip, a vertical flip and a palette number (8 palettes).

The pixel position inside the tile is flipped as the entry asks. The word holding that pixel is then fetched from tile memory. Tiles are packed five 3-bit pixels to a 16-bit word, so one tile takes 52 words, and the word address is found with a multiply by 52 and a divide by 5. Both memories are external and synchronous: the block drives an address and takes the read data on the following cycle. The output is the palette number joined with the 3-bit pixel value.

Top module: `bg_tile_fetch`

## Requirements
- R1: After reset, `color_valid`, `color_idx`, `attr_addr` and `tile_addr` are all zero.
- R2: The canvas position is cx = (scr_x + scroll_x) mod 640 and cy = (scr_y + scroll_y) mod 480. This holds for scroll_x from 0 to 639, scroll_y from 0 to 479, scr_x below 640 and scr_y below 480.
- R3: One cycle after a pixel is accepted (`px_valid` high at a clock edge), `attr_addr` equals (cy div 16) * 40 + (cx div 16).
- R4: `attr_rdata` is taken one cycle after `attr_addr` is driven. In the entry, bits 9:0 are the tile index, bit 10 is the horizontal flip, bit 11 is the vertical flip and bits 14:12 are the palette. Bit 15 is ignored.
- R5: Within a tile, column c = cx mod 16 becomes 15 - c when the horizontal flip is set, and row r = cy mod 16 becomes 15 - r when the vertical flip is set. The pixel number is p = r*16 + c, counted row by row from the top-left corner.
- R6: Three cycles after a pixel is accepted, `tile_addr` equals 52*t + floor(p/5), where t is the tile index. This includes p = 255, which lies in the last word of a tile (word 51).
- R7: `tile_rdata` is taken one cycle after `tile_addr` is driven. The pixel value is bits 3k+2 down to 3k of that word, where k = p mod 5.
- R8: Five cycles after a pixel is accepted, `color_valid` is high and `color_idx` equals {palette, pixel value}. Results come out in acceptance order, one per accepted pixel, and `color_valid` is low in every other cycle.
- R9: While `color_valid` is low, `color_idx` is zero. `attr_addr` and `tile_addr` keep their last value in any cycle in which no pixel passes through their stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pipeline clock |
| rst | input | 1 | Synchronous active-high reset |
| px_valid | input | 1 | A screen coordinate is presented this cycle |
| scr_x | input | 10 | Screen column |
| scr_y | input | 9 | Screen row |
| scroll_x | input | 10 | Horizontal canvas scroll |
| scroll_y | input | 9 | Vertical canvas scroll |
| attr_addr | output | 11 | Attribute memory word address |
| attr_rdata | input | 16 | Attribute memory read data, one cycle after the address |
| tile_addr | output | 16 | Tile memory word address |
| tile_rdata | input | 16 | Tile memory read data, one cycle after the address |
| color_valid | output | 1 | `color_idx` carries a result |
| color_idx | output | 6 | Palette number (bits 5:3) and pixel value (bits 2:0) |

## Verification
A pixel accepted at clock edge n shows up on `attr_addr` after edge n+1, on `tile_addr` after edge n+3, and on `color_valid`/`color_idx` after edge n+5. When a stimulus is driven, the bench computes all three results and files each one under the cycle in which it falls due. It also models both synchronous memories, so read data arrives one cycle after each address. Every bus is compared on the falling edge against the entry for that cycle. In idle cycles the bench expects the value held from the previous cycle, so gaps in `px_valid` check the hold and zero rules as well as the data path.

// File: rtl/bgf_pkg.sv
package bgf_pkg;

    localparam int CANVAS_W       = 640;
    localparam int CANVAS_H       = 480;
    localparam int TILE_LOG       = 4;
    localparam int TILE_SIDE      = 1 << TILE_LOG;
    localparam int TILES_X        = CANVAS_W / TILE_SIDE;
    localparam int TILES_Y        = CANVAS_H / TILE_SIDE;
    localparam int ATTR_DEPTH     = TILES_X * TILES_Y;
    localparam int ATTR_AW        = $clog2(ATTR_DEPTH);
    localparam int TILE_IDX_W     = 10;
    localparam int TILE_COUNT     = 1 << TILE_IDX_W;
    localparam int PIX_W          = 3;
    localparam int PIX_PER_WORD   = 5;
    localparam int WORD_W         = 16;
    localparam int PIX_PER_TILE   = TILE_SIDE * TILE_SIDE;
    localparam int WORDS_PER_TILE = (PIX_PER_TILE + PIX_PER_WORD - 1) / PIX_PER_WORD;
    localparam int TADDR_W        = $clog2(WORDS_PER_TILE * TILE_COUNT);
    localparam int PAL_W          = 3;
    localparam int COLOR_W        = PAL_W + PIX_W;
    localparam int XS_W           = $clog2(CANVAS_W);
    localparam int YS_W           = $clog2(CANVAS_H);
    localparam int PNUM_W         = 2 * TILE_LOG;
    localparam int SUB_W          = $clog2(PIX_PER_WORD);
    localparam int WIDX_W         = $clog2(WORDS_PER_TILE);

    // attribute entry layout (bit 15 spare)
    typedef struct packed {
        logic                  spare;
        logic [PAL_W-1:0]      pal;
        logic                  vflip;
        logic                  hflip;
        logic [TILE_IDX_W-1:0] tile;
    } attr_t;

    // position inside a tile, carried with the stage valid
    typedef struct packed {
        logic                v;
        logic [TILE_LOG-1:0] tx;
        logic [TILE_LOG-1:0] ty;
    } loc_t;

    // pixel slot within a word plus palette
    typedef struct packed {
        logic             v;
        logic [SUB_W-1:0] sub;
        logic [PAL_W-1:0] pal;
    } sel_t;

    // floor(p/5) by reciprocal multiply, exact for p < 1024
    function automatic logic [WIDX_W-1:0] div5(input logic [PNUM_W-1:0] p);
        logic [PNUM_W+10-1:0] m;
        m = {10'd0, p} * (PNUM_W + 10)'(205);
        return WIDX_W'(m >> 10);
    endfunction

    function automatic logic [SUB_W-1:0] mod5(input logic [PNUM_W-1:0] p);
        logic [PNUM_W-1:0] q5;
        q5 = PNUM_W'(div5(p)) * PNUM_W'(PIX_PER_WORD);
        return SUB_W'(p - q5);
    endfunction

endpackage

// File: rtl/bgf_canvas_map.sv
module bgf_canvas_map
    import bgf_pkg::*;
(
    input  logic [XS_W-1:0]     scr_x,
    input  logic [YS_W-1:0]     scr_y,
    input  logic [XS_W-1:0]     scroll_x,
    input  logic [YS_W-1:0]     scroll_y,
    output logic [ATTR_AW-1:0]  attr_idx,
    output logic [TILE_LOG-1:0] tx,
    output logic [TILE_LOG-1:0] ty
);
    logic [XS_W:0]   sum_x;
    logic [YS_W:0]   sum_y;
    logic [XS_W-1:0] cx;
    logic [YS_W-1:0] cy;
    logic [XS_W-TILE_LOG-1:0] col;
    logic [YS_W-TILE_LOG-1:0] row;

    always_comb begin
        sum_x = {1'b0, scr_x} + {1'b0, scroll_x};
        sum_y = {1'b0, scr_y} + {1'b0, scroll_y};
        cx = (sum_x >= (XS_W+1)'(CANVAS_W)) ? XS_W'(sum_x - (XS_W+1)'(CANVAS_W))
                                            : sum_x[XS_W-1:0];
        cy = (sum_y >= (YS_W+1)'(CANVAS_H)) ? YS_W'(sum_y - (YS_W+1)'(CANVAS_H))
                                            : sum_y[YS_W-1:0];
        col = cx[XS_W-1:TILE_LOG];
        row = cy[YS_W-1:TILE_LOG];
        tx  = cx[TILE_LOG-1:0];
        ty  = cy[TILE_LOG-1:0];
        attr_idx = ATTR_AW'(int'(row) * TILES_X + int'(col));
    end
endmodule

// File: rtl/bgf_word_locate.sv
module bgf_word_locate
    import bgf_pkg::*;
(
    input  attr_t               entry,
    input  logic [TILE_LOG-1:0] tx,
    input  logic [TILE_LOG-1:0] ty,
    output logic [TADDR_W-1:0]  word_addr,
    output logic [SUB_W-1:0]    sub
);
    logic [TILE_LOG-1:0] col;
    logic [TILE_LOG-1:0] row;
    logic [PNUM_W-1:0]   pnum;

    always_comb begin
        col  = entry.hflip ? ~tx : tx;
        row  = entry.vflip ? ~ty : ty;
        pnum = {row, col};
        word_addr = TADDR_W'(int'(entry.tile) * WORDS_PER_TILE + int'(div5(pnum)));
        sub  = mod5(pnum);
    end
endmodule

// File: rtl/bgf_pixel_pick.sv
module bgf_pixel_pick
    import bgf_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic [SUB_W-1:0]  sub,
    output logic [PIX_W-1:0]  pixel
);
    logic [PIX_W-1:0] slot [PIX_PER_WORD];
    logic unused_pad;

    for (genvar k = 0; k < PIX_PER_WORD; k++) begin : g_slot
        assign slot[k] = word[PIX_W*k +: PIX_W];
    end

    assign unused_pad = ^word[WORD_W-1:PIX_W*PIX_PER_WORD];

    always_comb begin
        pixel = '0;
        for (int k = 0; k < PIX_PER_WORD; k++) begin
            if (sub == SUB_W'(k)) pixel = slot[k];
        end
    end
endmodule

// File: rtl/bg_tile_fetch.sv
module bg_tile_fetch
    import bgf_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 px_valid,
    input  logic [XS_W-1:0]      scr_x,
    input  logic [YS_W-1:0]      scr_y,
    input  logic [XS_W-1:0]      scroll_x,
    input  logic [YS_W-1:0]      scroll_y,
    output logic [ATTR_AW-1:0]   attr_addr,
    input  logic [WORD_W-1:0]    attr_rdata,
    output logic [TADDR_W-1:0]   tile_addr,
    input  logic [WORD_W-1:0]    tile_rdata,
    output logic                 color_valid,
    output logic [COLOR_W-1:0]   color_idx
);
    // stage 1: canvas map, attribute address
    logic [ATTR_AW-1:0]  map_idx;
    logic [TILE_LOG-1:0] map_tx, map_ty;
    loc_t                s1, s2;

    bgf_canvas_map u_map (
        .scr_x    (scr_x),
        .scr_y    (scr_y),
        .scroll_x (scroll_x),
        .scroll_y (scroll_y),
        .attr_idx (map_idx),
        .tx       (map_tx),
        .ty       (map_ty)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            s1        <= '0;
            attr_addr <= '0;
        end else begin
            s1.v <= px_valid;
            if (px_valid) begin
                attr_addr <= map_idx;
                s1.tx     <= map_tx;
                s1.ty     <= map_ty;
            end
        end
    end

    // stage 2: attribute data arrives
    always_ff @(posedge clk) begin
        if (rst) s2 <= '0;
        else     s2 <= s1;
    end

    // stage 3: flip, tile word address
    attr_t               entry;
    logic [TADDR_W-1:0]  loc_addr;
    logic [SUB_W-1:0]    loc_sub;
    sel_t                s3, s4;

    assign entry = attr_t'(attr_rdata);

    bgf_word_locate u_loc (
        .entry     (entry),
        .tx        (s2.tx),
        .ty        (s2.ty),
        .word_addr (loc_addr),
        .sub       (loc_sub)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            s3        <= '0;
            tile_addr <= '0;
        end else begin
            s3.v <= s2.v;
            if (s2.v) begin
                tile_addr <= loc_addr;
                s3.sub    <= loc_sub;
                s3.pal    <= entry.pal;
            end
        end
    end

    // stage 4: tile data arrives
    always_ff @(posedge clk) begin
        if (rst) s4 <= '0;
        else     s4 <= s3;
    end

    // stage 5: pixel extraction
    logic [PIX_W-1:0] pick;

    bgf_pixel_pick u_pick (
        .word  (tile_rdata),
        .sub   (s4.sub),
        .pixel (pick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            color_valid <= 1'b0;
            color_idx   <= '0;
        end else begin
            color_valid <= s4.v;
            color_idx   <= s4.v ? {s4.pal, pick} : '0;
        end
    end

    logic unused_spare;
    assign unused_spare = entry.spare;
endmodule

// File: rtl/bgf_checker.sv
module bgf_checker
    import bgf_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               px_valid,
    input logic [ATTR_AW-1:0] attr_addr,
    input logic [TADDR_W-1:0] tile_addr,
    input logic               color_valid,
    input logic [COLOR_W-1:0] color_idx
);
    logic [2:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst)                since_rst <= '0;
        else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
    end

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 3'd5) |-> (color_valid == $past(px_valid, 5))); // R8

    AST_ATTR_RANGE: assert property (@(posedge clk) disable iff (rst)
        attr_addr < ATTR_AW'(ATTR_DEPTH)); // R3

    AST_TILE_RANGE: assert property (@(posedge clk) disable iff (rst)
        32'(tile_addr) < WORDS_PER_TILE * TILE_COUNT); // R6

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !color_valid |-> (color_idx == '0)); // R9

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !px_valid |=> $stable(attr_addr)); // R9
endmodule

bind bg_tile_fetch bgf_checker chk_i (
    .clk         (clk),
    .rst         (rst),
    .px_valid    (px_valid),
    .attr_addr   (attr_addr),
    .tile_addr   (tile_addr),
    .color_valid (color_valid),
    .color_idx   (color_idx)
);

// File: tb/bg_tile_fetch_tb.sv
module bg_tile_fetch_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        px_valid = 1'b0;
    logic [9:0]  scr_x = '0;
    logic [8:0]  scr_y = '0;
    logic [9:0]  scroll_x = '0;
    logic [8:0]  scroll_y = '0;
    logic [10:0] attr_addr;
    logic [15:0] attr_rdata = '0;
    logic [15:0] tile_addr;
    logic [15:0] tile_rdata = '0;
    logic        color_valid;
    logic [5:0]  color_idx;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit chk_en = 0;

    localparam int HORIZON = 8192;
    logic [10:0] exp_attr [HORIZON];
    logic [15:0] exp_tile [HORIZON];
    logic        exp_ov   [HORIZON];
    logic [5:0]  exp_col  [HORIZON];

    always #2 clk = ~clk;

    bg_tile_fetch dut_i (
        .clk(clk), .rst(rst), .px_valid(px_valid),
        .scr_x(scr_x), .scr_y(scr_y), .scroll_x(scroll_x), .scroll_y(scroll_y),
        .attr_addr(attr_addr), .attr_rdata(attr_rdata),
        .tile_addr(tile_addr), .tile_rdata(tile_rdata),
        .color_valid(color_valid), .color_idx(color_idx)
    );

    // memory contents, computed from the address
    function automatic logic [15:0] attr_fn(input logic [10:0] a);
        logic [15:0] r;
        r[9:0]   = 10'((int'(a) * 37 + 11) % 1024);
        r[10]    = a[0] ^ a[3];
        r[11]    = a[1] ^ a[4];
        r[14:12] = a[2:0] ^ a[7:5];
        r[15]    = a[2];
        return r;
    endfunction

    function automatic logic [15:0] tile_fn(input logic [15:0] a);
        return 16'(int'(a) * 40503 + (int'(a) >> 3) + 7);
    endfunction

    // synchronous memory models
    always @(posedge clk) begin
        cyc        <= cyc + 1;
        attr_rdata <= attr_fn(attr_addr);
        tile_rdata <= tile_fn(tile_addr);
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s cycle %0d actual %0h expected %0h", tag, cyc, act, exp);
        end
    endtask

    // drive one cycle (called just after a falling edge) and file expectations
    task automatic drive(input bit v, input int x, input int y, input int sx, input int sy);
        int c, cx, cy, aidx, t, tx, ty, p, taddr;
        logic [15:0] e, w;
        c = cyc;
        px_valid = v;
        scr_x = 10'(x); scr_y = 9'(y); scroll_x = 10'(sx); scroll_y = 9'(sy);
        if (v) begin
            cx = (x + sx) % 640;                       // R2
            cy = (y + sy) % 480;
            aidx = (cy / 16) * 40 + cx / 16;            // R3
            e = attr_fn(11'(aidx));
            t = int'(e[9:0]);                           // R4
            tx = cx % 16; ty = cy % 16;
            if (e[10]) tx = 15 - tx;                    // R5
            if (e[11]) ty = 15 - ty;
            p = ty * 16 + tx;
            taddr = 52 * t + p / 5;                     // R6
            w = tile_fn(16'(taddr));
            exp_attr[c+1] = 11'(aidx);
            exp_tile[c+3] = 16'(taddr);
            exp_ov[c+5]   = 1'b1;
            exp_col[c+5]  = {e[14:12], 3'((w >> (3 * (p % 5))) & 16'h7)}; // R7
        end else begin
            exp_attr[c+1] = exp_attr[c];
            exp_tile[c+3] = exp_tile[c+2];
            exp_ov[c+5]   = 1'b0;
            exp_col[c+5]  = '0;
        end
        @(negedge clk);
    endtask

    always @(negedge clk) begin
        if (chk_en && !done) begin
            chk("R3 (R2) attr_addr", int'(attr_addr), int'(exp_attr[cyc]));
            chk("R6 (R4 R5 R9) tile_addr", int'(tile_addr), int'(exp_tile[cyc]));
            chk("R8 color_valid", int'(color_valid), int'(exp_ov[cyc]));
            chk(exp_ov[cyc] ? "R7 R8 color_idx" : "R9 idle color_idx",
                int'(color_idx), int'(exp_col[cyc]));
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset color_valid", int'(color_valid), 0);
        chk("R1 reset color_idx", int'(color_idx), 0);
        chk("R1 reset attr_addr", int'(attr_addr), 0);
        chk("R1 reset tile_addr", int'(tile_addr), 0);
        for (int i = 0; i < HORIZON; i++) begin
            exp_attr[i] = '0; exp_tile[i] = '0; exp_ov[i] = 1'b0; exp_col[i] = '0;
        end
        chk_en = 1;
        // no scroll, scattered pixels with gaps
        for (int i = 0; i < 120; i++)
            drive((i % 7) != 3, (i * 7) % 320, (i * 3) % 240, 0, 0);
        // last pixel of tile 0 position: p = 255 when no flip applies
        drive(1, 15, 15, 0, 0);
        drive(1, 0, 0, 0, 0);
        drive(1, 31, 15, 0, 0);
        // wrap on both axes
        for (int i = 0; i < 200; i++)
            drive((i % 5) != 0, (i * 13) % 320, 200 + (i % 40), 630, 470);
        for (int i = 0; i < 60; i++)
            drive(1, 319 - i, 239 - (i % 16), 639, 479);
        // long idle gap, addresses must hold
        for (int i = 0; i < 12; i++) drive(0, 0, 0, 0, 0);
        // scroll changing every pixel, back-to-back
        for (int i = 0; i < 300; i++)
            drive(1, (i * 11) % 320, (i * 17) % 240, (i * 29) % 640, (i * 23) % 480);
        for (int i = 0; i < 40; i++)
            drive(i[0], i * 8, i * 6, 320 + i, 240 + i);
        for (int i = 0; i < 8; i++) drive(0, 0, 0, 0, 0);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired at cycle %0d actual running expected finished", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule